// File: doc/BRIEF.md
# PLL Bring-Up Sequencer

This block reprograms one clock-generator PLL. A one-cycle start pulse latches the requested reference divider NR, feedback multiplier NF and output divider NO. The block then drives the PLL control fields in a fixed order. First the PLL is parked on the reference in slow mode and held in reset. Next the three divider fields are loaded, together with a bandwidth-adjust value derived from NF. Reset is held for a timed interval, then released, and the block waits for the PLL's lock indication. Only after lock does it switch the mode field to normal and pulse `done`. If lock never arrives within a set number of cycles, the block gives up. It puts the PLL back into reset in slow mode and raises `err`.

The block also reports a frequency in hertz. It is computed from the current mode field and the programmed divider fields. Slow mode reports the 24 MHz reference. Normal mode reports 24 MHz × NF / (NR × NO), rounded down. The remaining mode codes (2 and 3, a deep-slow setting that this sequencer never drives) report 32768 Hz. The PLL itself is outside the block and is seen only through its lock input.

Top module: `pll_seq_top`

## Requirements
- R1: After reset, the outputs are as follows. `pll_mode` is 0 (slow). `pll_rst`, `busy`, `done` and `err` are 0. All divider fields are 0. `freq_hz` reads 24000000.
- R2: A start pulse is accepted while idle. On the clock edge that samples it, `pll_mode` becomes 0 (slow), `pll_rst` becomes 1 and `busy` becomes 1, all in that same edge.
- R3: One edge after acceptance, the fields take these values: `nr_fld` = NR−1, `nf_fld` = NF−1 and `no_fld` = NO−1.
- R4: On that same edge, `bw_fld` is loaded with (NF >> 1) − 1, truncated to the NF field width.
- R5: `pll_rst` stays high for exactly HOLD_CYC + 2 cycles counted from acceptance, where HOLD_CYC = CLK_MHZ × HOLD_US. This is a full HOLD_CYC after the programming cycle.
- R6: `pll_mode` stays 0 until `pll_lock` is sampled high after reset release. On that edge, `pll_mode` becomes 1 (normal) and `done` pulses for one cycle. If lock and the timeout fall on the same edge, lock wins.
- R7: A start pulse that arrives while `busy` is high has no effect. The fields, the reset timing and the outcome all follow the first request.
- R8: `busy` is high from acceptance until the edge that raises `done` or `err`, and it is never high together with `done`.
- R9: Suppose `pll_lock` stays low for LOCK_TMO cycles after reset release. On the LOCK_TMO-th edge, `err` becomes 1, `busy` becomes 0, `pll_rst` becomes 1 again and `pll_mode` stays 0. `err` clears when the next start is accepted.
- R10: `freq_hz` reads 24000000 while `pll_mode` is 0. It reads floor(24000000 × NF / (NR × NO)) while `pll_mode` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; accepted only while idle |
| nr_req | input | NR_W | Requested reference divider NR (1 or more) |
| nf_req | input | NF_W | Requested feedback multiplier NF (2 or more) |
| no_req | input | NO_W | Requested output divider NO (1 or more) |
| pll_lock | input | 1 | Lock status from the PLL |
| pll_mode | output | 2 | PLL mode field: 0 slow, 1 normal |
| pll_rst | output | 1 | PLL reset, active high |
| nr_fld | output | NR_W | Reference divider field, NR−1 |
| nf_fld | output | NF_W | Feedback divider field, NF−1 |
| no_fld | output | NO_W | Output divider field, NO−1 |
| bw_fld | output | NF_W | Bandwidth-adjust field, (NF>>1)−1 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on entering normal mode |
| err | output | 1 | Lock timeout flag |
| freq_hz | output | 40 | Reported output frequency in hertz |

## Verification
The bench builds the block with CLK_MHZ = 4 and HOLD_US = 10, which gives a 40-cycle hold, and with LOCK_TMO = 64. At these sizes the exact reset-hold length and the exact timeout edge can be counted cycle by cycle within a few hundred cycles per sequence. Lock delays cover the whole window, from immediate lock through the edge where lock and timeout coincide. The divider widths stay at their defaults, so the frequency readback is exercised with the largest NR, NF and NO as well as the smallest.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [1:0] {
        MODE_SLOW   = 2'd0,
        MODE_NORMAL = 2'd1,
        MODE_DEEP   = 2'd2
    } pll_mode_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROG,
        S_HOLD,
        S_RELEASE,
        S_WAIT
    } seq_state_e;

    localparam logic [63:0] REF_HZ   = 64'd24_000_000;
    localparam logic [63:0] SLEEP_HZ = 64'd32_768;
    localparam int          FREQ_W   = 40;

    // Reported frequency from the mode code and the minus-one divider fields.
    function automatic logic [FREQ_W-1:0] rate_hz(
        input logic [1:0]  mode,
        input logic [15:0] nr_f,
        input logic [15:0] nf_f,
        input logic [15:0] no_f
    );
        logic [63:0] num;
        logic [63:0] den;
        logic [63:0] res;
        num = REF_HZ * (64'(nf_f) + 64'd1);
        den = (64'(nr_f) + 64'd1) * (64'(no_f) + 64'd1);
        case (mode)
            MODE_SLOW:   res = REF_HZ;
            MODE_NORMAL: res = num / den;
            default:     res = SLEEP_HZ;
        endcase
        return res[FREQ_W-1:0];
    endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
    parameter int HOLD_CYC = 1000,
    parameter int TMO_CYC  = 65536
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic hold_hit,
    output logic tmo_hit
);
    localparam int MAXC = (HOLD_CYC > TMO_CYC) ? HOLD_CYC : TMO_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt != CW'(MAXC)) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign hold_hit = run && (cnt == CW'(HOLD_CYC - 1));
    assign tmo_hit  = run && (cnt == CW'(TMO_CYC - 1));

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt == '0));

endmodule

// File: rtl/pll_seq_freq.sv
module pll_seq_freq
    import pll_seq_pkg::*;
#(
    parameter int NR_W = 6,
    parameter int NF_W = 13,
    parameter int NO_W = 4
) (
    input  logic [1:0]        mode,
    input  logic [NR_W-1:0]   nr_f,
    input  logic [NF_W-1:0]   nf_f,
    input  logic [NO_W-1:0]   no_f,
    output logic [FREQ_W-1:0] hz
);
    assign hz = rate_hz(mode, 16'(nr_f), 16'(nf_f), 16'(no_f));
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter int NR_W = 6,
    parameter int NF_W = 13,
    parameter int NO_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [NR_W-1:0] nr_req,
    input  logic [NF_W-1:0] nf_req,
    input  logic [NO_W-1:0] no_req,
    input  logic            pll_lock,
    input  logic            hold_hit,
    input  logic            tmo_hit,
    output logic            timer_run,
    output logic [1:0]      pll_mode,
    output logic            pll_rst,
    output logic [NR_W-1:0] nr_fld,
    output logic [NF_W-1:0] nf_fld,
    output logic [NO_W-1:0] no_fld,
    output logic [NF_W-1:0] bw_fld,
    output logic            busy,
    output logic            done,
    output logic            err
);
    typedef struct packed {
        logic [NR_W-1:0] nr;
        logic [NF_W-1:0] nf;
        logic [NO_W-1:0] no;
    } req_t;

    seq_state_e state;
    pll_mode_e  mode_q;
    req_t       req_q;

    assign timer_run = (state == S_HOLD) || (state == S_WAIT);
    assign pll_mode  = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            mode_q  <= MODE_SLOW;
            pll_rst <= 1'b0;
            req_q   <= '0;
            nr_fld  <= '0;
            nf_fld  <= '0;
            no_fld  <= '0;
            bw_fld  <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        req_q   <= '{nr: nr_req, nf: nf_req, no: no_req};
                        mode_q  <= MODE_SLOW;
                        pll_rst <= 1'b1;
                        busy    <= 1'b1;
                        err     <= 1'b0;
                        state   <= S_PROG;
                    end
                end
                S_PROG: begin
                    nr_fld <= req_q.nr - NR_W'(1);
                    nf_fld <= req_q.nf - NF_W'(1);
                    no_fld <= req_q.no - NO_W'(1);
                    bw_fld <= (req_q.nf >> 1) - NF_W'(1);
                    state  <= S_HOLD;
                end
                S_HOLD: begin
                    if (hold_hit) state <= S_RELEASE;
                end
                S_RELEASE: begin
                    pll_rst <= 1'b0;
                    state   <= S_WAIT;
                end
                S_WAIT: begin
                    if (pll_lock) begin
                        mode_q <= MODE_NORMAL;
                        done   <= 1'b1;
                        busy   <= 1'b0;
                        state  <= S_IDLE;
                    end else if (tmo_hit) begin
                        err     <= 1'b1;
                        busy    <= 1'b0;
                        pll_rst <= 1'b1;
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2
    enter_slow_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_rst) |-> (pll_mode == MODE_SLOW));

    // R5
    release_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == S_RELEASE) |-> $past(hold_hit));

    // R6
    normal_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pll_mode == MODE_NORMAL) |-> $past(pll_lock));

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9
    err_not_normal_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> (pll_mode == MODE_SLOW) && pll_rst);

endmodule

// File: rtl/pll_seq_top.sv
module pll_seq_top
    import pll_seq_pkg::*;
#(
    parameter int NR_W     = 6,
    parameter int NF_W     = 13,
    parameter int NO_W     = 4,
    parameter int CLK_MHZ  = 100,
    parameter int HOLD_US  = 10,
    parameter int LOCK_TMO = 65536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [NR_W-1:0]   nr_req,
    input  logic [NF_W-1:0]   nf_req,
    input  logic [NO_W-1:0]   no_req,
    input  logic              pll_lock,
    output logic [1:0]        pll_mode,
    output logic              pll_rst,
    output logic [NR_W-1:0]   nr_fld,
    output logic [NF_W-1:0]   nf_fld,
    output logic [NO_W-1:0]   no_fld,
    output logic [NF_W-1:0]   bw_fld,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [FREQ_W-1:0] freq_hz
);
    localparam int HOLD_CYC = CLK_MHZ * HOLD_US;

    logic timer_run;
    logic hold_hit;
    logic tmo_hit;

    pll_seq_timer #(
        .HOLD_CYC (HOLD_CYC),
        .TMO_CYC  (LOCK_TMO)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .run      (timer_run),
        .hold_hit (hold_hit),
        .tmo_hit  (tmo_hit)
    );

    pll_seq_fsm #(
        .NR_W (NR_W),
        .NF_W (NF_W),
        .NO_W (NO_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .nr_req    (nr_req),
        .nf_req    (nf_req),
        .no_req    (no_req),
        .pll_lock  (pll_lock),
        .hold_hit  (hold_hit),
        .tmo_hit   (tmo_hit),
        .timer_run (timer_run),
        .pll_mode  (pll_mode),
        .pll_rst   (pll_rst),
        .nr_fld    (nr_fld),
        .nf_fld    (nf_fld),
        .no_fld    (no_fld),
        .bw_fld    (bw_fld),
        .busy      (busy),
        .done      (done),
        .err       (err)
    );

    pll_seq_freq #(
        .NR_W (NR_W),
        .NF_W (NF_W),
        .NO_W (NO_W)
    ) u_freq (
        .mode (pll_mode),
        .nr_f (nr_fld),
        .nf_f (nf_fld),
        .no_f (no_fld),
        .hz   (freq_hz)
    );

endmodule

// File: tb/pll_seq_top_tb.sv
module pll_seq_top_tb;
    localparam int NR_W = 6, NF_W = 13, NO_W = 4;
    localparam int CLK_MHZ = 4, HOLD_US = 10, LOCK_TMO = 64;
    localparam int HOLD_CYC = CLK_MHZ * HOLD_US;

    logic clk = 0, rst = 1, start = 0, pll_lock = 0;
    logic [NR_W-1:0] nr_req = '0;
    logic [NF_W-1:0] nf_req = '0;
    logic [NO_W-1:0] no_req = '0;
    logic [1:0] pll_mode;
    logic pll_rst, busy, done, err;
    logic [NR_W-1:0] nr_fld;
    logic [NF_W-1:0] nf_fld, bw_fld;
    logic [NO_W-1:0] no_fld;
    logic [39:0] freq_hz;

    int n_run = 0, n_fail = 0;
    bit finished = 0;

    pll_seq_top #(.NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .CLK_MHZ(CLK_MHZ),
                  .HOLD_US(HOLD_US), .LOCK_TMO(LOCK_TMO)) u_dut (
        .clk(clk), .rst(rst), .start(start), .nr_req(nr_req), .nf_req(nf_req),
        .no_req(no_req), .pll_lock(pll_lock), .pll_mode(pll_mode), .pll_rst(pll_rst),
        .nr_fld(nr_fld), .nf_fld(nf_fld), .no_fld(no_fld), .bw_fld(bw_fld),
        .busy(busy), .done(done), .err(err), .freq_hz(freq_hz));

    always #5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic longint exp_hz(input int nr, input int nf, input int no);
        return (longint'(24000000) * nf) / (nr * no);
    endfunction

    // One full sequence; d = cycles after release before lock (negative: never)
    task automatic run_seq(input int nr, input int nf, input int no, input int d, input bit inject);
        int rc, lat;
        nr_req = NR_W'(nr); nf_req = NF_W'(nf); no_req = NO_W'(no);
        start = 1; step(); start = 0;
        chk(pll_rst && pll_mode == 2'd0, "R2 rst/mode", {pll_rst, pll_mode}, 3'b100);
        chk(busy == 1, "R8 busy on accept", busy, 1);
        chk(err == 0, "R9 err cleared by start", err, 0);
        step();
        chk(nr_fld == NR_W'(nr - 1) && no_fld == NO_W'(no - 1), "R3 nr/no fields",
            {nr_fld, no_fld}, {NR_W'(nr - 1), NO_W'(no - 1)});
        chk(nf_fld == NF_W'(nf - 1), "R3 nf field", nf_fld, NF_W'(nf - 1));
        chk(bw_fld == NF_W'((nf >> 1) - 1), "R4 bwadj", bw_fld, NF_W'((nf >> 1) - 1));
        rc = 2;
        for (int n = 0; n < 4 * HOLD_CYC && pll_rst; n++) begin
            if (inject && n == 3) begin
                start = 1; nr_req = NR_W'(nr + 2); nf_req = NF_W'(nf + 7); no_req = NO_W'(no % 15 + 1);
            end
            step();
            start = 0;
            if (pll_rst) rc++;
            if (n == 5) begin
                chk(freq_hz == 40'd24000000, "R10 slow readback", freq_hz, 24000000);
                chk(busy == 1 && pll_mode == 2'd0, "R8 busy during hold", busy, 1);
            end
        end
        chk(rc == HOLD_CYC + 2, "R5 reset hold length", rc, HOLD_CYC + 2);
        if (inject) begin
            chk(nr_fld == NR_W'(nr - 1) && nf_fld == NF_W'(nf - 1) && no_fld == NO_W'(no - 1),
                "R7 mid-run start ignored", nf_fld, NF_W'(nf - 1));
        end
        lat = 0;
        for (int k = 0; k < LOCK_TMO + 8; k++) begin
            if (d >= 0 && lat == d) pll_lock = 1;
            step();
            lat++;
            if (done || err) break;
            if (k == 0) chk(pll_mode == 2'd0, "R6 slow before lock", pll_mode, 0);
        end
        if (d >= 0) begin
            chk(done == 1 && lat == d + 1, "R6 done edge", lat, d + 1);
            chk(pll_mode == 2'd1, "R6 normal mode", pll_mode, 1);
            chk(busy == 0 && err == 0, "R8 busy drop", {busy, err}, 0);
            chk(freq_hz == 40'(exp_hz(nr, nf, no)), "R10 normal readback", freq_hz, exp_hz(nr, nf, no));
            pll_lock = 0;
            step();
            chk(done == 0, "R6 done one cycle", done, 0);
        end else begin
            chk(err == 1 && lat == LOCK_TMO, "R9 timeout edge", lat, LOCK_TMO);
            chk(busy == 0 && pll_rst == 1 && pll_mode == 2'd0 && done == 0, "R9 error outputs",
                {busy, pll_rst, pll_mode, done}, 5'b01000);
            step();
        end
    endtask

    initial begin : watchdog
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        step(); step();
        rst = 0;
        step();
        // R1 reset state
        chk(pll_mode == 2'd0 && pll_rst == 0, "R1 mode/rst", {pll_mode, pll_rst}, 0);
        chk(busy == 0 && done == 0 && err == 0, "R1 flags", {busy, done, err}, 0);
        chk(nr_fld == 0 && nf_fld == 0 && no_fld == 0 && bw_fld == 0, "R1 fields", nf_fld, 0);
        chk(freq_hz == 40'd24000000, "R1 readback", freq_hz, 24000000);

        // directed corners
        run_seq(1, 2, 1, 0, 0);
        run_seq(63, 8191, 15, 5, 1);
        run_seq(12, 800, 2, LOCK_TMO - 2, 0);
        run_seq(1, 100, 4, -1, 0);
        run_seq(2, 111, 1, LOCK_TMO - 1, 0);
        run_seq(3, 200, 2, -1, 1);
        run_seq(1, 48, 2, 3, 0);

        for (int i = 0; i < 20; i++) begin
            int nr, nf, no, d;
            nr = 1 + int'($urandom % 63);
            nf = 2 + int'($urandom % 8190);
            no = 1 + int'($urandom % 15);
            d  = ($urandom % 6 == 0) ? -1 : int'($urandom % LOCK_TMO);
            run_seq(nr, nf, no, d, ($urandom % 3) == 0);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule